// File: doc/BRIEF.md
# GPIO Bank with Edge Capture

This block is one 32-pin general-purpose I/O bank. Software reaches it through a small word-addressed register port: a write strobe, a word address, write data and a registered read-data bus. For each pin the bank holds an output-enable bit and an output latch. The output latch is changed only through two write-one registers, one that sets bits and one that clears bits, so software never needs a read-modify-write to move a single pin.

The pad levels pass through a two-stage synchronizer. The synchronized value can be read back, and it also feeds per-pin rising and falling edge detectors. Capture of a detected edge depends on two things. The edge's direction must be enabled for that pin, and the pin must not be blocked by a mask bit. A captured edge sets a sticky status bit, which stays set until software writes a one to it. One interrupt output reports that at least one status bit is pending. The bank also stores a 2-bit function-select field for each of its low 16 pins, for use by logic outside the bank.

Top module: `gpio_edge_bank`

## Requirements
- R1: After a synchronous reset the register contents are as follows. Output enables, output latch, both edge-enable words, edge status and function-select word are all zero. The capture mask is all ones. `irq` is low.
- R2: Word address 3 holds the direction word, which can be read and written. A bit of 1 makes that pin an output. `pin_oe` follows the written value from the clock edge of the write.
- R3: A write to word address 6 sets every latch bit whose data bit is 1 and leaves every other bit unchanged. `pin_out` shows the result from that clock edge. Reads at address 6 return the latch.
- R4: A write to word address 9 clears every latch bit whose data bit is 1 and leaves every other bit unchanged. Reads at address 9 return the latch.
- R5: Word address 0 returns the synchronized level of all 32 `pin_in` bits, whether a pin is an input or an output. A pad change appears on `rdata` at the third rising clock edge after it, provided the address is held. Writes to address 0 change nothing.
- R6: Word address 12 is the rising-edge enable and word address 15 is the falling-edge enable. An unmasked pin sets its status bit in word 18 on a 0-to-1 change only if its rising enable is 1, and on a 1-to-0 change only if its falling enable is 1.
- R7: Status bits are sticky. A write to word 18 clears exactly the bits written as 1, so all ones clears every bit and zeros leave every bit unchanged.
- R8: Word address 39 is the capture mask. A mask bit of 1 stops that pin from setting its status bit, whatever its enables are.
- R9: If an edge capture and a write-one-to-clear hit the same status bit in the same cycle, the bit stays set.
- R10: `irq` is high exactly when at least one status bit is set. It changes at the same clock edge as the status word.
- R11: Word address 21 is a 32-bit function-select word that can be read and written. Pin n, for n from 0 to 15, owns bits 2n+1:2n.
- R12: `rdata` is registered. It shows the register addressed during the previous cycle. Word addresses with no register read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 6 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Pad levels, asynchronous |
| pin_out | output | 32 | Output latch |
| pin_oe | output | 32 | Per-pin output enable (1 = drive) |
| irq | output | 1 | Any edge status bit pending |

## Verification
Register writes take effect at the clock edge that samples the strobe. The bench looks at `pin_oe` and `pin_out` at the falling edge after that clock edge, and a read of the same register returns the new value one clock after its address is presented. A pad change reaches the synchronized level after two clock edges and the status word and `irq` after three. The bench therefore checks the level read and `irq` on both sides of those edges. It also times the colliding write-one-to-clear so that its strobe lands on exactly the edge where the status bit is captured. In the random phases every pad change is given at least four clocks to settle before the status word is read.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  // Word addresses of the bank registers
  localparam int unsigned WA_LEVEL = 0;
  localparam int unsigned WA_DIR   = 3;
  localparam int unsigned WA_SET   = 6;
  localparam int unsigned WA_CLR   = 9;
  localparam int unsigned WA_RISE  = 12;
  localparam int unsigned WA_FALL  = 15;
  localparam int unsigned WA_STAT  = 18;
  localparam int unsigned WA_FSEL  = 21;
  localparam int unsigned WA_MASK  = 39;
endpackage

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync #(
  parameter int PIN_W  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIN_W-1:0] din,
  output logic [PIN_W-1:0] dout
);
  logic [PIN_W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= '0;
    else     stage[0] <= din;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[i] <= '0;
      else     stage[i] <= stage[i-1];
    end
  end

  assign dout = stage[STAGES-1];
endmodule

// File: rtl/gpio_edge_capture.sv
module gpio_edge_capture #(
  parameter int PIN_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIN_W-1:0] level,
  input  logic [PIN_W-1:0] en_rise,
  input  logic [PIN_W-1:0] en_fall,
  input  logic [PIN_W-1:0] cap_mask,
  input  logic [PIN_W-1:0] clr_bits,
  output logic [PIN_W-1:0] status,
  output logic             irq
);
  logic [PIN_W-1:0] level_q;
  logic [PIN_W-1:0] went_up, went_down, captured, status_d;

  always_comb begin
    went_up   = level & ~level_q;
    went_down = ~level & level_q;
    captured  = ((went_up & en_rise) | (went_down & en_fall)) & ~cap_mask;
    // a fresh capture overrides a same-cycle clear
    status_d  = (status & ~clr_bits) | captured;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= '0;
      status  <= '0;
      irq     <= 1'b0;
    end else begin
      level_q <= level;
      status  <= status_d;
      irq     <= |status_d;
    end
  end
endmodule

// File: rtl/gpio_edge_regs.sv
module gpio_edge_regs
  import gpio_edge_pkg::*;
#(
  parameter int PIN_W  = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PIN_W-1:0]  wdata,
  input  logic [PIN_W-1:0]  level,
  input  logic [PIN_W-1:0]  status,
  output logic [PIN_W-1:0]  dir_q,
  output logic [PIN_W-1:0]  out_q,
  output logic [PIN_W-1:0]  rise_q,
  output logic [PIN_W-1:0]  fall_q,
  output logic [PIN_W-1:0]  mask_q,
  output logic [PIN_W-1:0]  clr_bits,
  output logic [PIN_W-1:0]  rdata
);
  localparam logic [ADDR_W-1:0] A_LEVEL = ADDR_W'(WA_LEVEL);
  localparam logic [ADDR_W-1:0] A_DIR   = ADDR_W'(WA_DIR);
  localparam logic [ADDR_W-1:0] A_SET   = ADDR_W'(WA_SET);
  localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(WA_CLR);
  localparam logic [ADDR_W-1:0] A_RISE  = ADDR_W'(WA_RISE);
  localparam logic [ADDR_W-1:0] A_FALL  = ADDR_W'(WA_FALL);
  localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(WA_STAT);
  localparam logic [ADDR_W-1:0] A_FSEL  = ADDR_W'(WA_FSEL);
  localparam logic [ADDR_W-1:0] A_MASK  = ADDR_W'(WA_MASK);

  logic [PIN_W-1:0] fsel_q;
  logic [PIN_W-1:0] rd_mux;

  assign clr_bits = (wr_en && addr == A_STAT) ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '0;
      out_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      mask_q <= '1;
      fsel_q <= '0;
    end else if (wr_en) begin
      case (addr)
        A_DIR:   dir_q  <= wdata;
        A_SET:   out_q  <= out_q | wdata;
        A_CLR:   out_q  <= out_q & ~wdata;
        A_RISE:  rise_q <= wdata;
        A_FALL:  fall_q <= wdata;
        A_FSEL:  fsel_q <= wdata;
        A_MASK:  mask_q <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      A_LEVEL: rd_mux = level;
      A_DIR:   rd_mux = dir_q;
      A_SET:   rd_mux = out_q;
      A_CLR:   rd_mux = out_q;
      A_RISE:  rd_mux = rise_q;
      A_FALL:  rd_mux = fall_q;
      A_STAT:  rd_mux = status;
      A_FSEL:  rd_mux = fsel_q;
      A_MASK:  rd_mux = mask_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank #(
  parameter int PIN_W       = 32,
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PIN_W-1:0]  wdata,
  output logic [PIN_W-1:0]  rdata,
  input  logic [PIN_W-1:0]  pin_in,
  output logic [PIN_W-1:0]  pin_out,
  output logic [PIN_W-1:0]  pin_oe,
  output logic              irq
);
  logic [PIN_W-1:0] level, status, rise_q, fall_q, mask_q, clr_bits;

  gpio_edge_sync #(.PIN_W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst (rst), .din (pin_in), .dout (level)
  );

  gpio_edge_capture #(.PIN_W(PIN_W)) u_cap (
    .clk      (clk),
    .rst      (rst),
    .level    (level),
    .en_rise  (rise_q),
    .en_fall  (fall_q),
    .cap_mask (mask_q),
    .clr_bits (clr_bits),
    .status   (status),
    .irq      (irq)
  );

  gpio_edge_regs #(.PIN_W(PIN_W), .ADDR_W(ADDR_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .level    (level),
    .status   (status),
    .dir_q    (pin_oe),
    .out_q    (pin_out),
    .rise_q   (rise_q),
    .fall_q   (fall_q),
    .mask_q   (mask_q),
    .clr_bits (clr_bits),
    .rdata    (rdata)
  );
endmodule

// File: rtl/gpio_edge_bank_chk.sv
module gpio_edge_bank_chk
  import gpio_edge_pkg::*;
#(
  parameter int PIN_W  = 32,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [PIN_W-1:0]  wdata,
  input logic [PIN_W-1:0]  pin_out,
  input logic [PIN_W-1:0]  pin_oe,
  input logic              irq
);
  logic wr_dir, wr_set, wr_clr, wr_stat;
  assign wr_dir  = wr_en && addr == ADDR_W'(WA_DIR);
  assign wr_set  = wr_en && addr == ADDR_W'(WA_SET);
  assign wr_clr  = wr_en && addr == ADDR_W'(WA_CLR);
  assign wr_stat = wr_en && addr == ADDR_W'(WA_STAT);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (pin_oe == '0 && pin_out == '0 && !irq));

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_dir |=> pin_oe == $past(wdata));

  // R3
  set_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_set |=> pin_out == ($past(pin_out) | $past(wdata)));

  // R4
  clr_write_chk: assert property (@(posedge clk) disable iff (rst)
    wr_clr |=> pin_out == ($past(pin_out) & ~$past(wdata)));

  // R3
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_set || wr_clr) |=> $stable(pin_out));

  // R7
  irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && !wr_stat) |=> irq);
endmodule

bind gpio_edge_bank gpio_edge_bank_chk #(.PIN_W(PIN_W), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .addr    (addr),
  .wdata   (wdata),
  .pin_out (pin_out),
  .pin_oe  (pin_oe),
  .irq     (irq)
);

// File: tb/gpio_edge_bank_tb.sv
module gpio_edge_bank_tb;
  localparam int W = 32;
  localparam int AW = 6;
  localparam int A_LEVEL = 0, A_DIR = 3, A_SET = 6, A_CLR = 9, A_RISE = 12,
                 A_FALL = 15, A_STAT = 18, A_FSEL = 21, A_MASK = 39;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata, pin_out, pin_oe;
  logic [W-1:0] pin_in = '0;
  logic irq;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  // bench model
  logic [W-1:0] m_dir, m_out, m_rise, m_fall, m_mask, m_fsel, m_stat, m_pins;

  always #2 clk = ~clk;

  gpio_edge_bank #(.PIN_W(W), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq(irq)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b0; addr = AW'(a);
    @(negedge clk);
    d = rdata;
  endtask

  task automatic set_pins(input logic [W-1:0] v);
    @(negedge clk);
    pin_in = v;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  // expected value of a readable register
  function automatic logic [W-1:0] exp_reg(input int a);
    case (a)
      A_LEVEL: return m_pins;
      A_DIR:   return m_dir;
      A_SET, A_CLR: return m_out;
      A_RISE:  return m_rise;
      A_FALL:  return m_fall;
      A_STAT:  return m_stat;
      A_FSEL:  return m_fsel;
      A_MASK:  return m_mask;
      default: return '0;
    endcase
  endfunction

  // model update for a register write
  function automatic void model_wr(input int a, input logic [W-1:0] d);
    case (a)
      A_DIR:  m_dir  = d;
      A_SET:  m_out  = m_out | d;
      A_CLR:  m_out  = m_out & ~d;
      A_RISE: m_rise = d;
      A_FALL: m_fall = d;
      A_STAT: m_stat = m_stat & ~d;
      A_FSEL: m_fsel = d;
      A_MASK: m_mask = d;
      default: ;
    endcase
  endfunction

  // model update for a pad change
  function automatic void model_pins(input logic [W-1:0] nv);
    logic [W-1:0] up, dn;
    up = nv & ~m_pins;
    dn = ~nv & m_pins;
    m_stat = m_stat | (((up & m_rise) | (dn & m_fall)) & ~m_mask);
    m_pins = nv;
  endfunction

  task automatic mwr(input int a, input logic [W-1:0] d);
    wr(a, d);
    model_wr(a, d);
  endtask

  task automatic mpins(input logic [W-1:0] v);
    set_pins(v);
    model_pins(v);
    settle();
  endtask

  initial begin
    logic [W-1:0] v;
    int regs [9] = '{A_LEVEL, A_DIR, A_SET, A_CLR, A_RISE, A_FALL, A_STAT, A_FSEL, A_MASK};
    void'($urandom(32'h5eed_0c1d));
    m_dir = '0; m_out = '0; m_rise = '0; m_fall = '0; m_mask = '1;
    m_fsel = '0; m_stat = '0; m_pins = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 pin_oe", pin_oe, '0);
    check("R1 pin_out", pin_out, '0);
    check("R1 irq", {31'b0, irq}, '0);
    rd(A_MASK, v); check("R1 mask", v, '1);
    rd(A_RISE, v); check("R1 rise", v, '0);
    rd(A_FALL, v); check("R1 fall", v, '0);
    rd(A_STAT, v); check("R1 status", v, '0);
    rd(A_FSEL, v); check("R1 fsel", v, '0);

    // R2 direction
    mwr(A_DIR, 32'hA5A5_0F0F);
    check("R2 pin_oe", pin_oe, 32'hA5A5_0F0F);
    rd(A_DIR, v); check("R2 readback", v, 32'hA5A5_0F0F);

    // R3 / R4 set and clear
    mwr(A_SET, 32'h0000_00FF); check("R3 set", pin_out, 32'h0000_00FF);
    mwr(A_SET, 32'h0000_0100); check("R3 zeros keep", pin_out, 32'h0000_01FF);
    mwr(A_CLR, 32'h0000_000F); check("R4 clear", pin_out, 32'h0000_01F0);
    rd(A_CLR, v); check("R4 readback", v, 32'h0000_01F0);
    rd(A_SET, v); check("R3 readback", v, 32'h0000_01F0);

    // R5 level timing: hold address, change pads
    @(negedge clk); addr = AW'(A_LEVEL);
    @(negedge clk); check("R5 level before", rdata, '0);
    pin_in = 32'hDEAD_BEEF; m_pins = 32'hDEAD_BEEF;
    @(negedge clk); check("R5 level edge1", rdata, '0);
    @(negedge clk); check("R5 level edge2", rdata, '0);
    @(negedge clk); check("R5 level edge3", rdata, 32'hDEAD_BEEF);
    wr(A_LEVEL, 32'h1234_5678);
    rd(A_LEVEL, v); check("R5 write ignored", v, 32'hDEAD_BEEF);
    mpins('0);

    // R11 function select: pin 5 field = 2, pin 15 field = 3
    mwr(A_FSEL, (32'd2 << 10) | (32'd3 << 30));
    rd(A_FSEL, v); check("R11 fsel", v, 32'hC000_0800);

    // R12 unmapped reads
    rd(1, v);  check("R12 unmapped 1", v, '0);
    rd(40, v); check("R12 unmapped 40", v, '0);
    rd(63, v); check("R12 unmapped 63", v, '0);

    // R6 / R8 edge capture
    mwr(A_MASK, 32'h0000_0004);
    mwr(A_RISE, 32'h0000_0005);
    mwr(A_FALL, 32'h0000_0006);
    mpins(32'h0000_0001);
    rd(A_STAT, v); check("R6 rising captured", v, 32'h1);
    mpins(32'h0000_0003);
    rd(A_STAT, v); check("R6 rising not enabled", v, 32'h1);
    mpins(32'h0000_0001);
    rd(A_STAT, v); check("R6 falling captured", v, 32'h3);
    mpins(32'h0000_0005);
    mpins(32'h0000_0001);
    rd(A_STAT, v); check("R8 masked pin", v, 32'h3);

    // R7 sticky and write-one-to-clear
    mwr(A_STAT, 32'h0);
    rd(A_STAT, v); check("R7 zero write keeps", v, 32'h3);
    mwr(A_STAT, '1);
    rd(A_STAT, v); check("R7 all ones clears", v, '0);
    check("R7 irq low", {31'b0, irq}, '0);

    // R10 irq timing on pin 3 rising
    mwr(A_RISE, 32'h0000_0008);
    @(negedge clk); pin_in = 32'h0000_0009; model_pins(32'h0000_0009);
    @(negedge clk);
    @(negedge clk); check("R10 irq before capture", {31'b0, irq}, '0);
    @(negedge clk); check("R10 irq at capture", {31'b0, irq}, 32'h1);
    rd(A_STAT, v); check("R10 status", v, 32'h8);
    mwr(A_STAT, 32'h8);
    check("R10 irq cleared", {31'b0, irq}, '0);

    // R9 edge wins over same-cycle clear, pin 4
    mwr(A_RISE, 32'h0000_0010);
    mwr(A_FALL, 32'h0000_0010);
    mpins(32'h0000_0019);
    rd(A_STAT, v); check("R9 setup", v, 32'h10);
    @(negedge clk); pin_in = 32'h0000_0009;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; addr = AW'(A_STAT); wdata = 32'h10;
    @(negedge clk); wr_en = 1'b0;
    m_pins = 32'h0000_0009;
    rd(A_STAT, v); check("R9 edge wins", v, 32'h10);
    check("R9 irq", {31'b0, irq}, 32'h1);
    mwr(A_STAT, '1);

    // random register traffic, pads static
    for (int i = 0; i < 60; i++) begin
      int a, b;
      logic [W-1:0] d;
      a = regs[$urandom_range(0, 8)];
      b = regs[$urandom_range(0, 8)];
      d = $urandom;
      mwr(a, d);
      rd(b, v); check("R12 random readback", v, exp_reg(b));
      check("R2 random pin_oe", pin_oe, m_dir);
      check("R3 random pin_out", pin_out, m_out);
    end

    // random edge traffic
    mwr(A_STAT, '1);
    for (int i = 0; i < 60; i++) begin
      if (i % 10 == 0) begin
        mwr(A_RISE, $urandom);
        mwr(A_FALL, $urandom);
        mwr(A_MASK, $urandom & $urandom);
      end
      mpins($urandom);
      rd(A_STAT, v); check("R6 random status", v, m_stat);
      check("R10 random irq", {31'b0, irq}, {31'b0, |m_stat});
      if (i % 3 == 0) begin
        mwr(A_STAT, $urandom);
        rd(A_STAT, v); check("R7 random clear", v, m_stat);
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule